// File: doc/BRIEF.md
# Window-Constrained Check Neighbour Enumerator

This block lists every check-node index that one bit node of a low-density parity-check decoder may be wired to when the wires must stay inside a rectangular window. Bit nodes fill a grid of `ROWS` rows by `COLS` columns. Check nodes fill a grid with the same number of rows and half as many columns, so each check row holds `COLS/2` entries. The window spans `VSPAN` rows and `HSPAN` columns. A code-construction engine gives the block a bit index with a one-cycle start pulse. The block then returns the candidate check indices one per cycle. It marks the final candidate and pulses done on the following cycle.

The bit's own check row is the home row. Candidates come from a two-level walk. The outer walk moves through check rows in a fixed alternation: first the home row, then the row above it, then the row below the home row, then the second row above, and so on. The inner walk moves left and right inside the current row, starting from the column under the bit. Each step is clipped against the ends of the check array and against the edges of its row. No cycle is spent on a candidate that is clipped. Every row offset is measured from the original centre index, not from a running value.

Top module: `chk_nbr_enum`

## Requirements
- R1: After reset, and whenever no request is in progress, `outValid`, `outLast` and `doneOut` are low.
- R2: For bit index i, the bit row is i / COLS and the bit column is i mod COLS. The centre index is (column + row×COLS)/2, rounded down. The centre index is the first value emitted. It appears in the cycle after the clock edge that samples `startIn`.
- R3: Let V = VSPAN/2 and W = COLS/2. For t = 1 to V in turn, the block first visits the row t−1 below the bit row, using centre + (t−1)×W. It then visits the row t above, using centre − t×W.
- R4: The lower row of step t is skipped unless centre + (t−1)×W < ROWS×W. The upper row of step t is skipped unless centre − t×W ≥ 0.
- R5: Inside a visited row with row centre a, the block emits a first. It then emits a+k followed by a−k, for k = 1 up to the horizontal reach, leaving out any clipped value.
- R6: In check row r, a+k is emitted only if it is below W×(r+1), and a−k only if it is at least W×r.
- R7: `outValid` stays high on every cycle from the first candidate to the last, with no gaps. `outLast` is high only together with the final candidate.
- R8: `doneOut` is high for exactly one cycle: the cycle after the one in which `outLast` is high. `outValid` is low in that cycle.
- R9: A start pulse that arrives while a request is streaming or while `doneOut` is high is ignored. The stream already in progress does not change, and no new stream begins.
- R10: With ROWS=4, COLS=8, VSPAN=2 and HSPAN=3, bit 16 yields the sequence 8, 9, 10, 4, 5, 6.
- R11: The horizontal reach is the parameter `HREACH`, whose default is HSPAN−1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Request strobe, sampled only when idle |
| bitIdx | input | $clog2(ROWS*COLS) | Bit-node index of the request |
| outValid | output | 1 | A candidate check index is present |
| outIdx | output | $clog2(ROWS*COLS/2) | Candidate check-node index |
| outLast | output | 1 | Marks the final candidate of the request |
| doneOut | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked on every cycle:
- The outputs stay quiet while idle.
- The first candidate is the centre index.
- Every candidate lies inside the row band and column band around the captured bit.
- The stream is contiguous up to the last flag.
- The done pulse follows the last flag and lasts one cycle.

Only the bench scenarios can show the exact order of rows and columns and that no legal candidate is missing. They also show the fixed example for bit 16 and that start pulses during a stream or a done cycle are ignored. To do this, the bench compares each stream with an arithmetic model for every bit index of both configurations.

// File: rtl/chk_nbr_pkg.sv
package chk_nbr_pkg;

  // Strobes sent from the sequencer to the walk datapath
  typedef struct packed {
    logic load;   // capture a new bit index and reset both walks
    logic stepH;  // move to the next candidate in the current row
    logic stepV;  // move to the next legal row, restart at its centre
  } nbrStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EMIT = 2'd1,
    ST_DONE = 2'd2
  } nbrState_t;

endpackage

// File: rtl/chk_nbr_dp.sv
module chk_nbr_dp
  import chk_nbr_pkg::*;
#(
  parameter int ROWS   = 32,
  parameter int COLS   = 32,
  parameter int VSPAN  = 16,
  parameter int HREACH = 14,
  localparam int IDX_W = $clog2(ROWS * COLS),
  localparam int CHK_W = $clog2(ROWS * COLS / 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  nbrStrobe_t       strobe,
  input  logic [IDX_W-1:0] bitIdx,
  output logic [CHK_W-1:0] candIdx,
  output logic             hEnd,
  output logic             vEnd
);

  localparam int CW   = COLS / 2;
  localparam int VR   = VSPAN / 2;
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CCW  = (CW > 1) ? $clog2(CW) : 1;
  localparam int T_W  = $clog2(VR + 2);
  localparam int KW   = $clog2(HREACH + 2);

  logic [RW-1:0]  rowR;     // row of the requested bit
  logic [CCW-1:0] colH;     // column of the centre check inside a row
  logic [T_W-1:0] tStep;    // vertical step number, starts at 1
  logic           upDir;    // 0: lower row of this step, 1: upper row
  logic [KW-1:0]  hk;       // horizontal distance from row centre
  logic           hMinus;   // current candidate is on the minus side

  int plusLim, minusLim;
  int rowCur, rowBase, candVal;
  int nextK, nextT;
  logic nextMinus, nextUp;
  logic afterPlus, plusNext, minusNext;

  // Row legality, expressed in row numbers relative to the bit row
  function automatic logic downOk(input int t, input int r);
    return (t <= VR) && (r + t - 1 < ROWS);
  endfunction

  function automatic logic upOk(input int t, input int r);
    return (t <= VR) && (t <= r);
  endfunction

  // Candidate value and horizontal limits
  always_comb begin
    plusLim  = CW - 1 - int'(colH);
    if (plusLim > HREACH) plusLim = HREACH;
    minusLim = int'(colH);
    if (minusLim > HREACH) minusLim = HREACH;
    rowCur   = upDir ? (int'(rowR) - int'(tStep)) : (int'(rowR) + int'(tStep) - 1);
    rowBase  = rowCur * CW + int'(colH);
    candVal  = hMinus ? (rowBase - int'(hk)) : (rowBase + int'(hk));
    candIdx  = CHK_W'(candVal);
  end

  // Inner walk: centre, then +k / -k pairs, skipping clipped sides
  always_comb begin
    afterPlus = !hMinus && (hk != '0) && (int'(hk) <= minusLim);
    plusNext  = (int'(hk) + 1) <= plusLim;
    minusNext = (int'(hk) + 1) <= minusLim;
    hEnd      = !afterPlus && !plusNext && !minusNext;
    if (afterPlus) begin
      nextK     = int'(hk);
      nextMinus = 1'b1;
    end else if (plusNext) begin
      nextK     = int'(hk) + 1;
      nextMinus = 1'b0;
    end else begin
      nextK     = int'(hk) + 1;
      nextMinus = 1'b1;
    end
  end

  // Outer walk: lower row of step t, upper row of step t, then t+1
  always_comb begin
    nextT  = int'(tStep);
    nextUp = 1'b0;
    vEnd   = 1'b0;
    if (!upDir) begin
      if (upOk(int'(tStep), int'(rowR))) begin
        nextT  = int'(tStep);
        nextUp = 1'b1;
      end else if (downOk(int'(tStep) + 1, int'(rowR))) begin
        nextT  = int'(tStep) + 1;
        nextUp = 1'b0;
      end else begin
        vEnd = 1'b1;
      end
    end else begin
      if (downOk(int'(tStep) + 1, int'(rowR))) begin
        nextT  = int'(tStep) + 1;
        nextUp = 1'b0;
      end else if (upOk(int'(tStep) + 1, int'(rowR))) begin
        nextT  = int'(tStep) + 1;
        nextUp = 1'b1;
      end else begin
        vEnd = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowR   <= '0;
      colH   <= '0;
      tStep  <= T_W'(1);
      upDir  <= 1'b0;
      hk     <= '0;
      hMinus <= 1'b0;
    end else if (strobe.load) begin
      rowR   <= RW'(int'(bitIdx) / COLS);
      colH   <= CCW'((int'(bitIdx) % COLS) / 2);
      tStep  <= T_W'(1);
      upDir  <= 1'b0;
      hk     <= '0;
      hMinus <= 1'b0;
    end else if (strobe.stepV) begin
      tStep  <= T_W'(nextT);
      upDir  <= nextUp;
      hk     <= '0;
      hMinus <= 1'b0;
    end else if (strobe.stepH) begin
      hk     <= KW'(nextK);
      hMinus <= nextMinus;
    end
  end

endmodule

// File: rtl/chk_nbr_ctrl.sv
module chk_nbr_ctrl
  import chk_nbr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       hEnd,
  input  logic       vEnd,
  output nbrStrobe_t strobe,
  output logic       outValid,
  output logic       outLast,
  output logic       doneOut
);

  nbrState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    outValid  = (state == ST_EMIT);
    outLast   = (state == ST_EMIT) && hEnd && vEnd;
    doneOut   = (state == ST_DONE);
    unique case (state)
      ST_IDLE: begin
        if (startIn) begin
          strobe.load = 1'b1;
          stateNext   = ST_EMIT;
        end
      end
      ST_EMIT: begin
        if (!hEnd)      strobe.stepH = 1'b1;
        else if (!vEnd) strobe.stepV = 1'b1;
        else            stateNext    = ST_DONE;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/chk_nbr_enum.sv
module chk_nbr_enum
  import chk_nbr_pkg::*;
#(
  parameter int ROWS   = 32,
  parameter int COLS   = 32,
  parameter int VSPAN  = 16,
  parameter int HSPAN  = 15,
  parameter int HREACH = HSPAN - 1,
  localparam int IDX_W = $clog2(ROWS * COLS),
  localparam int CHK_W = $clog2(ROWS * COLS / 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [IDX_W-1:0] bitIdx,
  output logic             outValid,
  output logic [CHK_W-1:0] outIdx,
  output logic             outLast,
  output logic             doneOut
);

  nbrStrobe_t strobe;
  logic hEnd, vEnd;

  chk_nbr_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .hEnd    (hEnd),
    .vEnd    (vEnd),
    .strobe  (strobe),
    .outValid(outValid),
    .outLast (outLast),
    .doneOut (doneOut)
  );

  chk_nbr_dp #(
    .ROWS  (ROWS),
    .COLS  (COLS),
    .VSPAN (VSPAN),
    .HREACH(HREACH)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .bitIdx (bitIdx),
    .candIdx(outIdx),
    .hEnd   (hEnd),
    .vEnd   (vEnd)
  );

endmodule

// File: rtl/chk_nbr_chk.sv
module chk_nbr_chk #(
  parameter int ROWS   = 32,
  parameter int COLS   = 32,
  parameter int VSPAN  = 16,
  parameter int HREACH = 14,
  localparam int IDX_W = $clog2(ROWS * COLS),
  localparam int CHK_W = $clog2(ROWS * COLS / 2)
) (
  input logic             clk,
  input logic             rstN,
  input logic             startIn,
  input logic [IDX_W-1:0] bitIdx,
  input logic             outValid,
  input logic [CHK_W-1:0] outIdx,
  input logic             outLast,
  input logic             doneOut
);

  localparam int CW = COLS / 2;
  localparam int VR = VSPAN / 2;

  logic busy;
  int   capRow, capCol;
  int   candRow, candCol;

  // Independent request tracker: accepts only when idle, frees on done
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      capRow <= 0;
      capCol <= 0;
    end else if (!busy && startIn) begin
      busy   <= 1'b1;
      capRow <= int'(bitIdx) / COLS;
      capCol <= (int'(bitIdx) % COLS) / 2;
    end else if (doneOut) begin
      busy <= 1'b0;
    end
  end

  always_comb begin
    candRow = int'(outIdx) / CW;
    candCol = int'(outIdx) % CW;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!outValid && !outLast && !doneOut));

  assert_first_centre_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !busy) |=> (outValid && (int'(outIdx) == int'($past(bitIdx)) / 2)));

  assert_row_band_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (int'(outIdx) < ROWS * CW && candRow >= capRow - VR && candRow <= capRow + VR - 1));

  assert_col_band_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (candCol - capCol <= HREACH && capCol - candCol <= HREACH));

  assert_last_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  assert_no_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLast) |=> outValid);

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rstN)
    outLast |=> (doneOut && !outValid));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  assert_done_needs_last_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLast) |=> !doneOut);

endmodule

bind chk_nbr_enum chk_nbr_chk #(
  .ROWS  (ROWS),
  .COLS  (COLS),
  .VSPAN (VSPAN),
  .HREACH(HREACH)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .startIn (startIn),
  .bitIdx  (bitIdx),
  .outValid(outValid),
  .outIdx  (outIdx),
  .outLast (outLast),
  .doneOut (doneOut)
);

// File: tb/chk_nbr_enum_tb.sv
module chk_nbr_enum_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int NBIG       = 4;   // parallel lanes of the 32x32 configuration
  localparam int NL         = 5;   // lane 4 is the 4x8 configuration

  typedef int intQ[$];

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic       startS [NL];
  logic [9:0] bitS   [NL];
  logic       valS   [NL];
  logic       lastS  [NL];
  logic       doneS  [NL];
  logic [9:0] idxS   [NL];
  int gotQ [NL][$];
  int nChk = 0;
  int nFail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Large configuration with the default reach HSPAN-1 (R11)
  for (genvar g = 0; g < NBIG; g++) begin : g_big
    logic [8:0] oIdx;
    chk_nbr_enum u_dut (
      .clk     (clk),
      .rstN    (rstN),
      .startIn (startS[g]),
      .bitIdx  (bitS[g]),
      .outValid(valS[g]),
      .outIdx  (oIdx),
      .outLast (lastS[g]),
      .doneOut (doneS[g])
    );
    assign idxS[g] = {1'b0, oIdx};
  end

  logic [3:0] smallIdx;
  chk_nbr_enum #(.ROWS(4), .COLS(8), .VSPAN(2), .HSPAN(3)) u_dutSmall (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startS[4]),
    .bitIdx  (bitS[4][4:0]),
    .outValid(valS[4]),
    .outIdx  (smallIdx),
    .outLast (lastS[4]),
    .doneOut (doneS[4])
  );
  assign idxS[4] = {6'd0, smallIdx};

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Arithmetic model: centre (R2), row order (R3), row limits (R4),
  // in-row order (R5) and row-edge clipping (R6)
  function automatic intQ buildExp(input int i, input int n, input int m,
                                   input int r, input int hr);
    intQ q;
    int w, row, col, c, tot;
    w = m / 2; row = i / m; col = i % m;
    c = (col + row * m) / 2; tot = n * w;
    for (int t = 1; t <= r / 2; t++) begin
      for (int s = 0; s < 2; s++) begin
        int a, rr;
        bit ok;
        a  = (s == 0) ? c + (t - 1) * w : c - t * w;
        rr = (s == 0) ? row + t - 1 : row - t;
        ok = (s == 0) ? (a < tot) : (a >= 0);
        if (ok) begin
          q.push_back(a);
          for (int k = 1; k <= hr; k++) begin
            if (a + k < w * (rr + 1)) q.push_back(a + k);
            if (a - k >= w * rr)      q.push_back(a - k);
          end
        end
      end
    end
    return q;
  endfunction

  task automatic runBit(input int ln, input int i, input int n, input int m,
                        input int r, input int hr, input bit poke);
    intQ exp;
    int pos;
    bit fin;
    exp = buildExp(i, n, m, r, hr);
    gotQ[ln].delete();
    @(negedge clk);
    startS[ln] = 1'b1;
    bitS[ln]   = 10'(i);
    @(negedge clk);
    startS[ln] = 1'b0;
    pos = 0;
    fin = 1'b0;
    while (!fin) begin
      if (!valS[ln]) begin
        check(1'b0, "R7 stream gap, bit", i, pos);
        fin = 1'b1;
      end else begin
        gotQ[ln].push_back(int'(idxS[ln]));
        if (pos < exp.size())
          check(int'(idxS[ln]) == exp[pos], (pos == 0) ? "R2 centre" : "R5 order", int'(idxS[ln]), exp[pos]);
        else
          check(1'b0, "R4 extra candidate", int'(idxS[ln]), -1);
        check(lastS[ln] == (pos == exp.size() - 1), "R7 last flag", int'(lastS[ln]), int'(pos == exp.size() - 1));
        // R9: a start during the stream must not disturb it
        startS[ln] = poke && (pos == 0);
        bitS[ln]   = poke ? 10'((i + 5) % (n * m)) : bitS[ln];
        if (lastS[ln] || pos >= exp.size() - 1) fin = 1'b1;
        pos++;
        @(negedge clk);
      end
    end
    check(doneS[ln] && !valS[ln], "R8 done after last", int'(doneS[ln]), 1);
    startS[ln] = poke;   // R9: start during the done cycle
    @(negedge clk);
    startS[ln] = 1'b0;
    check(!doneS[ln], "R8 done single cycle", int'(doneS[ln]), 0);
    check(!valS[ln], "R9 start while busy ignored", int'(valS[ln]), 0);
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WD_CYCLES);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin : main
    for (int l = 0; l < NL; l++) begin
      startS[l] = 1'b0;
      bitS[l]   = '0;
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    for (int l = 0; l < NL; l++)
      check(!valS[l] && !doneS[l] && !lastS[l], "R1 idle after reset", int'(valS[l]), 0);

    fork
      begin for (int i = 0;   i < 256;  i++) runBit(0, i, 32, 32, 16, 14, 1'b0); end
      begin for (int i = 256; i < 512;  i++) runBit(1, i, 32, 32, 16, 14, 1'b0); end
      begin for (int i = 512; i < 768;  i++) runBit(2, i, 32, 32, 16, 14, 1'b0); end
      begin for (int i = 768; i < 1024; i++) runBit(3, i, 32, 32, 16, 14, (i % 97) == 0); end
      begin
        for (int i = 0; i < 32; i++) runBit(4, i, 4, 8, 2, 2, (i % 3) == 0);
        // R10: fixed example, literal values, with busy pokes
        runBit(4, 16, 4, 8, 2, 2, 1'b1);
        check(gotQ[4].size() == 6, "R10 count", gotQ[4].size(), 6);
        if (gotQ[4].size() == 6) begin
          check(gotQ[4][0] == 8,  "R10 idx0", gotQ[4][0], 8);
          check(gotQ[4][1] == 9,  "R10 idx1", gotQ[4][1], 9);
          check(gotQ[4][2] == 10, "R10 idx2", gotQ[4][2], 10);
          check(gotQ[4][3] == 4,  "R10 idx3", gotQ[4][3], 4);
          check(gotQ[4][4] == 5,  "R10 idx4", gotQ[4][4], 5);
          check(gotQ[4][5] == 6,  "R10 idx5", gotQ[4][5], 6);
        end
      end
    join

    repeat (4) @(negedge clk);
    for (int l = 0; l < NL; l++)
      check(!valS[l] && !doneS[l], "R1 idle at end", int'(valS[l]), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule